// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the horizontal and vertical timing of a CRT-style display from a small set of byte-wide registers. A prescaler turns the system clock into a pixel tick. A pixel counter and a scan-line counter advance on that tick. Comparators against the programmed positions drive the sync and blank outputs, each with its own polarity. The block also gives a combined active-high blank, one-cycle end-of-line and end-of-frame pulses, and the current pixel and memory-line numbers for a pixel fetch engine.

All horizontal positions are programmed in groups of 8 pixels, and all vertical positions in groups of 8 scan lines. In line-doubling mode every memory line is shown on two consecutive scan lines, so a low-resolution picture fills a tall screen. A master enable bit holds the counters cleared and the outputs idle while software reprograms the timing.

Top module: `rsg_sync_gen`

## Requirements
- R1: Ten byte registers sit at offsets 0 to 9: 0 control, 1 prescaler, 2 horizontal visible width, 3 horizontal sync start, 4 horizontal sync end, 5 horizontal total, 6 vertical visible height, 7 vertical sync start, 8 vertical sync end, 9 vertical total. All reset to 0. A write with `cfg_we` high updates the addressed register at the next clock edge. `cfg_rdata` shows the addressed register in the same cycle. Offsets 10 to 15 read as 0, and writes to them change nothing.
- R2: While enabled, `pix_tick` is high in one cycle of every P+1 system clocks, where P is the prescaler register. The first tick comes P cycles after the enable takes effect.
- R3: While enabled, `pix_x` advances by one on each pixel tick and returns to 0 on the tick where it equals 8*Htotal-1.
- R4: The scan-line counter advances only on a tick where the pixel counter wraps. It returns to 0 on such a tick when it equals 8*Vtotal-1.
- R5: The raw horizontal sync is active for 8*HsyncStart <= x < 8*HsyncEnd, and the raw horizontal blank for x >= 8*Hvisible. The vertical raw signals follow the same rule on the scan-line counter.
- R6: Control bits 1, 2, 3 and 4 set the polarity of `hsync`, `vsync`, `hblank` and `vblank`. A 0 gives an active-high output and a 1 an active-low output.
- R7: `blank` is active-high regardless of polarity, and is the OR of the raw horizontal and vertical blanks.
- R8: `h_tc` is high for exactly the one cycle of the pixel tick on which the pixel counter wraps. `v_tc` is high only in that cycle when the scan-line counter also wraps.
- R9: With control bit 5 set, `mem_line` is the scan-line count divided by two, so each memory line covers two scan lines. With bit 5 clear, it equals the scan-line count.
- R10: With control bit 0 (enable) clear, the counters are cleared on the next edge. `pix_tick`, `h_tc` and `v_tc` are low. `pix_x` and `mem_line` are 0. `blank` is high. Each of the four timing outputs sits at its inactive level for its polarity.
- R11: Control bits 7:6 hold a colour-depth code (00=1, 01=2, 10=4, 11=8 bits per pixel). The code is stored and read back unchanged and has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_addr | input | ADDR_W | Register offset |
| cfg_wdata | input | 8 | Register write data |
| cfg_we | input | 1 | Register write strobe |
| cfg_rdata | output | 8 | Read data of the addressed register |
| pix_tick | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync, programmable polarity |
| vsync | output | 1 | Vertical sync, programmable polarity |
| hblank | output | 1 | Horizontal blank, programmable polarity |
| vblank | output | 1 | Vertical blank, programmable polarity |
| blank | output | 1 | Combined blank, active high |
| h_tc | output | 1 | End-of-line pulse |
| v_tc | output | 1 | End-of-frame pulse |
| pix_x | output | 8+UNIT_LOG2 | Current pixel in the line |
| mem_line | output | 8+UNIT_LOG2 | Current memory line |

## Verification
The bench keeps the default parameters (a 4-bit register offset and 8-pixel position units) and programs very short timings: 5 groups per line and 4 groups per frame. One frame is then 1280 pixel ticks, so several complete frames fit in each phase. The phases use prescaler values 0, 1 and 2, so the wrap of the pixel counter, the end-of-frame pulse and the halving of the line number in doubling mode all occur many times. Each phase also changes the polarity set, and the enable is dropped in the middle of a frame to exercise the hold-off state.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 10;

    // register offsets
    localparam int A_CTRL  = 0;
    localparam int A_PRESC = 1;
    localparam int A_H_VIS = 2;
    localparam int A_H_SS  = 3;
    localparam int A_H_SE  = 4;
    localparam int A_H_TOT = 5;
    localparam int A_V_VIS = 6;
    localparam int A_V_SS  = 7;
    localparam int A_V_SE  = 8;
    localparam int A_V_TOT = 9;

    // control bit positions
    localparam int B_EN     = 0;
    localparam int B_HS_POL = 1;
    localparam int B_VS_POL = 2;
    localparam int B_HB_POL = 3;
    localparam int B_VB_POL = 4;
    localparam int B_DBL    = 5;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic  en;
        logic  hs_pol;
        logic  vs_pol;
        logic  hb_pol;
        logic  vb_pol;
        logic  dbl;
        byte_t presc;
        byte_t h_vis;
        byte_t h_ss;
        byte_t h_se;
        byte_t h_tot;
        byte_t v_vis;
        byte_t v_ss;
        byte_t v_se;
        byte_t v_tot;
    } cfg_t;

    typedef struct packed {
        byte_t vis;
        byte_t ss;
        byte_t se;
        byte_t tot;
    } axis_cfg_t;
endpackage

// File: rtl/rsg_regs.sv
module rsg_regs
    import rsg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wdata,
    input  logic              we,
    output byte_t             rdata,
    output cfg_t              cfg
);
    typedef struct packed {
        byte_t [NUM_REGS-1:0] r;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata = st_q.r[i];
                if (we) begin
                    st_d.r[i] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg.en     = st_q.r[A_CTRL][B_EN];
    assign cfg.hs_pol = st_q.r[A_CTRL][B_HS_POL];
    assign cfg.vs_pol = st_q.r[A_CTRL][B_VS_POL];
    assign cfg.hb_pol = st_q.r[A_CTRL][B_HB_POL];
    assign cfg.vb_pol = st_q.r[A_CTRL][B_VB_POL];
    assign cfg.dbl    = st_q.r[A_CTRL][B_DBL];
    assign cfg.presc  = st_q.r[A_PRESC];
    assign cfg.h_vis  = st_q.r[A_H_VIS];
    assign cfg.h_ss   = st_q.r[A_H_SS];
    assign cfg.h_se   = st_q.r[A_H_SE];
    assign cfg.h_tot  = st_q.r[A_H_TOT];
    assign cfg.v_vis  = st_q.r[A_V_VIS];
    assign cfg.v_ss   = st_q.r[A_V_SS];
    assign cfg.v_se   = st_q.r[A_V_SE];
    assign cfg.v_tot  = st_q.r[A_V_TOT];
endmodule

// File: rtl/rsg_prescale.sv
module rsg_prescale
    import rsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  byte_t presc,
    output logic  tick
);
    typedef struct packed {
        byte_t cnt;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = en && (st_q.cnt == presc);
        if (!en || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rsg_axis.sv
module rsg_axis
    import rsg_pkg::*;
#(
    parameter  int UNIT_LOG2 = 3,
    localparam int CNT_W     = DATA_W + UNIT_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  axis_cfg_t        acfg,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last,
    output logic             sync_raw,
    output logic             blank_raw
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } axis_t;

    axis_t            st_d, st_q;
    logic [CNT_W-1:0] last_pos;

    function automatic logic [CNT_W-1:0] scale(input byte_t b);
        return {b, {UNIT_LOG2{1'b0}}};
    endfunction

    always_comb begin
        st_d      = st_q;
        last_pos  = scale(acfg.tot) - 1'b1;
        at_last   = (st_q.cnt >= last_pos);
        sync_raw  = (st_q.cnt >= scale(acfg.ss)) && (st_q.cnt < scale(acfg.se));
        blank_raw = (st_q.cnt >= scale(acfg.vis));
        if (clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = at_last ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/rsg_sync_gen.sv
module rsg_sync_gen
    import rsg_pkg::*;
#(
    parameter  int ADDR_W    = 4,
    parameter  int UNIT_LOG2 = 3,
    localparam int CNT_W     = DATA_W + UNIT_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              cfg_we,
    output logic [7:0]        cfg_rdata,
    output logic              pix_tick,
    output logic              hsync,
    output logic              vsync,
    output logic              hblank,
    output logic              vblank,
    output logic              blank,
    output logic              h_tc,
    output logic              v_tc,
    output logic [CNT_W-1:0]  pix_x,
    output logic [CNT_W-1:0]  mem_line
);
    localparam int N_AXES = 2;   // 0: horizontal, 1: vertical

    cfg_t             cfg;
    logic             tick;
    logic             run;
    axis_cfg_t        acfg      [N_AXES];
    logic             step      [N_AXES];
    logic [CNT_W-1:0] cnt       [N_AXES];
    logic             at_last   [N_AXES];
    logic             sync_raw  [N_AXES];
    logic             blank_raw [N_AXES];

    rsg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .we    (cfg_we),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    rsg_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg.en),
        .presc (cfg.presc),
        .tick  (tick)
    );

    assign run     = cfg.en;
    assign acfg[0] = '{vis: cfg.h_vis, ss: cfg.h_ss, se: cfg.h_se, tot: cfg.h_tot};
    assign acfg[1] = '{vis: cfg.v_vis, ss: cfg.v_ss, se: cfg.v_se, tot: cfg.v_tot};
    assign step[0] = tick;
    assign step[1] = tick & at_last[0];

    for (genvar g = 0; g < N_AXES; g++) begin : g_axis
        rsg_axis #(.UNIT_LOG2(UNIT_LOG2)) u_axis (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (!run),
            .step      (step[g]),
            .acfg      (acfg[g]),
            .cnt       (cnt[g]),
            .at_last   (at_last[g]),
            .sync_raw  (sync_raw[g]),
            .blank_raw (blank_raw[g])
        );
    end

    always_comb begin
        pix_tick = tick;
        h_tc     = step[1];
        v_tc     = step[1] & at_last[1];
        if (run) begin
            hsync    = sync_raw[0]  ^ cfg.hs_pol;
            vsync    = sync_raw[1]  ^ cfg.vs_pol;
            hblank   = blank_raw[0] ^ cfg.hb_pol;
            vblank   = blank_raw[1] ^ cfg.vb_pol;
            blank    = blank_raw[0] | blank_raw[1];
            pix_x    = cnt[0];
            mem_line = cfg.dbl ? (cnt[1] >> 1) : cnt[1];
        end else begin
            hsync    = cfg.hs_pol;
            vsync    = cfg.vs_pol;
            hblank   = cfg.hb_pol;
            vblank   = cfg.vb_pol;
            blank    = 1'b1;
            pix_x    = '0;
            mem_line = '0;
        end
    end
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             pix_tick,
    input logic             blank,
    input logic             h_tc,
    input logic             v_tc,
    input logic [CNT_W-1:0] pix_x,
    input logic [CNT_W-1:0] mem_line
);
    p_htc_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        h_tc |-> pix_tick);

    p_vtc_with_htc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        v_tc |-> h_tc);

    p_htc_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        h_tc |=> !h_tc);

    p_x_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !pix_tick) |=> (!run || $stable(pix_x)));

    p_x_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pix_tick && !h_tc) |=> (!run || pix_x == CNT_W'($past(pix_x) + 1'b1)));

    p_frame_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && v_tc) |=> (!run || (pix_x == '0 && mem_line == '0)));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (blank && !pix_tick && !h_tc && !v_tc));
endmodule

bind rsg_sync_gen rsg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .pix_tick (pix_tick),
    .blank    (blank),
    .h_tc     (h_tc),
    .v_tc     (v_tc),
    .pix_x    (pix_x),
    .mem_line (mem_line)
);

// File: tb/rsg_sync_gen_bench.sv
module rsg_sync_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic        cfg_we;
    logic [7:0]  cfg_rdata;
    logic        pix_tick, hsync, vsync, hblank, vblank, blank, h_tc, v_tc;
    logic [10:0] pix_x, mem_line;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // behavioural reference state
    int regs_m [16];
    int pc_m = 0;
    int h_m  = 0;
    int v_m  = 0;

    always #4 clk = ~clk;

    rsg_sync_gen u_rsg_sync_gen (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .pix_tick(pix_tick),
        .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
        .blank(blank), .h_tc(h_tc), .v_tc(v_tc), .pix_x(pix_x), .mem_line(mem_line)
    );

    function automatic void chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endfunction

    always @(negedge clk) begin
        int c, en, hp, vp, hbp, vbp, dbl, tick_e, hs, vs, hb, vb, htc, vtc, rd_e;
        c      = regs_m[0];
        en     = c & 1;
        hp     = (c >> 1) & 1;
        vp     = (c >> 2) & 1;
        hbp    = (c >> 3) & 1;
        vbp    = (c >> 4) & 1;
        dbl    = (c >> 5) & 1;
        tick_e = (en != 0) && (pc_m == regs_m[1]);
        hs     = (h_m >= regs_m[3] * 8) && (h_m < regs_m[4] * 8);
        hb     = (h_m >= regs_m[2] * 8);
        vs     = (v_m >= regs_m[7] * 8) && (v_m < regs_m[8] * 8);
        vb     = (v_m >= regs_m[6] * 8);
        htc    = tick_e && (h_m >= regs_m[5] * 8 - 1);
        vtc    = htc && (v_m >= regs_m[9] * 8 - 1);
        rd_e   = (int'(cfg_addr) < 10) ? regs_m[cfg_addr] : 0;

        chk("R1", "cfg_rdata", int'(cfg_rdata), rd_e);
        if (en != 0) begin
            chk("R2", "pix_tick", int'(pix_tick), tick_e);
            chk("R3", "pix_x", int'(pix_x), h_m);
            chk("R9", "mem_line", int'(mem_line), (dbl != 0) ? v_m / 2 : v_m);
            chk("R5", "hsync", int'(hsync), hs ^ hp);
            chk("R6", "vsync", int'(vsync), vs ^ vp);
            chk("R5", "hblank", int'(hblank), hb ^ hbp);
            chk("R6", "vblank", int'(vblank), vb ^ vbp);
            chk("R7", "blank", int'(blank), hb | vb);
            chk("R8", "h_tc", int'(h_tc), htc);
            chk("R4", "v_tc", int'(v_tc), vtc);
        end else begin
            chk("R10", "pix_tick", int'(pix_tick), 0);
            chk("R10", "pix_x", int'(pix_x), 0);
            chk("R10", "mem_line", int'(mem_line), 0);
            chk("R10", "hsync", int'(hsync), hp);
            chk("R10", "vsync", int'(vsync), vp);
            chk("R10", "hblank", int'(hblank), hbp);
            chk("R10", "vblank", int'(vblank), vbp);
            chk("R10", "blank", int'(blank), 1);
            chk("R10", "h_tc", int'(h_tc), 0);
            chk("R10", "v_tc", int'(v_tc), 0);
        end

        if (!rst_n) begin
            foreach (regs_m[i]) regs_m[i] = 0;
            pc_m = 0; h_m = 0; v_m = 0;
        end else begin
            if (en != 0) begin
                if (tick_e) begin
                    pc_m = 0;
                    if (htc) begin
                        h_m = 0;
                        if (vtc) v_m = 0;
                        else     v_m = v_m + 1;
                    end else begin
                        h_m = h_m + 1;
                    end
                end else begin
                    pc_m = (pc_m + 1) % 256;
                end
            end else begin
                pc_m = 0; h_m = 0; v_m = 0;
            end
            if (cfg_we && int'(cfg_addr) < 10) regs_m[cfg_addr] = int'(cfg_wdata);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic run_for(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            cfg_addr = cfg_addr + 1'b1;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_addr = '0; cfg_wdata = '0; cfg_we = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values swept by address, then writes to unmapped offsets
        run_for(20);
        wr(4'd12, 8'hAA);
        wr(4'd15, 8'h55);
        run_for(20);

        // phase A: prescaler 0, positive polarities, no doubling
        wr(4'd1, 8'd0);
        wr(4'd2, 8'd2); wr(4'd3, 8'd3); wr(4'd4, 8'd4); wr(4'd5, 8'd5);
        wr(4'd6, 8'd1); wr(4'd7, 8'd2); wr(4'd8, 8'd3); wr(4'd9, 8'd4);
        wr(4'd0, 8'h01);
        run_for(2700);

        // R10: disable, then reprogram with inverted polarities, doubling, depth code
        wr(4'd0, 8'h00);
        run_for(20);
        wr(4'd1, 8'd2);
        wr(4'd0, 8'hFF);
        @(posedge clk); #1; cfg_addr = 4'd0;
        @(negedge clk);
        chk("R11", "depth code readback", int'(cfg_rdata), 8'hFF);
        run_for(8000);

        // R10: drop enable mid-frame, polarities kept
        wr(4'd0, 8'h3E);
        run_for(30);

        // phase C: prescaler 1, doubling with positive polarities
        wr(4'd1, 8'd1);
        wr(4'd0, 8'h21);
        run_for(5300);

        finish_run();
    end
endmodule